// File: doc/BRIEF.md
# Fractional-Trim Nanosecond Time Counter

This block keeps a free-running 40-bit nanosecond time of day for packet timestamping. On each clock edge it adds a fixed 8 ns base step. Software tunes the rate through a signed sub-nanosecond trim. The trim magnitude goes into a 32-bit fraction accumulator on every tick. A carry out of the accumulator makes that tick 9 ns, and a borrow makes it 7 ns. The base step itself can never be changed.

Software reaches the block through a small word-wide register bus. There is a trim register, a control word whose top bit stops the timer, and three time words. Reads and writes of the time words are atomic across words. A read of the residue word latches a snapshot of the time, and later reads of the low and high words return that snapshot. A write of the low word is held in a staging register. The following write of the high word loads both words together. Trim units are 2^-32 ns per tick, so a rate offset of p ppb needs a magnitude of about p·2^26/1953125. The largest supported offset, 62,499,999 ppb, gives 0x7FFFFFDD.

Top module: `tod_trim_counter`

## Requirements
- R1: Reset clears the time, the fraction accumulator, the trim, the staging word and the read data, and sets control bit 31, so the timer starts stopped. A read of the control word (address 4) then returns 0x80000000.
- R2: While control bit 31 is set, neither the time nor the fraction accumulator changes.
- R3: While the timer runs with a trim magnitude of zero, the time advances by exactly 8 ns per clock.
- R4: With trim bit 31 clear, the magnitude in bits 30:0 is added to the fraction each tick. A tick whose addition carries out of 32 bits advances the time by 9 ns; every other tick advances it by 8 ns.
- R5: With trim bit 31 set, the magnitude is subtracted from the fraction each tick. A tick whose subtraction borrows advances the time by 7 ns; every other tick advances it by 8 ns.
- R6: A read of address 0 returns the fraction as it was before that edge and latches the 40-bit time. Later reads of address 1 (bits 31:0) and address 2 (bits 39:32) return the latched value until the next address-0 read. Read data appears one clock after the read strobe and holds until the next read.
- R7: A write to address 1 only stages the word. The running time is not disturbed.
- R8: A write to address 2 loads the time with {write data bits 7:0, staged word} on that edge in place of the tick, and clears the fraction accumulator.
- R9: The time wraps modulo 2^40 ns.
- R10: Reads of address 2 return zero in bits 31:8, and write data bits 31:8 to address 2 have no effect.
- R11: A write to address 4 stores bit 31 as the stop flag, and reads return {flag, 31 zeros}. The new flag governs ticks from the next edge on.
- R12: The trim register (address 3) reads back all 32 written bits. A new trim value governs ticks from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one tick per edge (8 ns nominal) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe |
| bus_addr_i | input | 3 | Register address: 0 residue, 1 low, 2 high, 3 trim, 4 control |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data, valid the clock after bus_re_i |
| time_ns_o | output | 40 | Live nanosecond time |

## Verification
A time load from a high-word write competes with the tick of the same edge. The bench writes the high word while the timer runs and while a nonzero trim has left a large fraction in the accumulator. The reference model expects exactly the loaded value, with no step added, and expects the following tick to start from a zero fraction. The bench also places a snapshot read next to running ticks and stop or trim writes. It expects the latched time to be the pre-edge value and expects a control change to leave the tick of its own edge untouched.

// File: rtl/tod_pkg.sv
package tod_pkg;
  typedef enum logic [2:0] {
    ADDR_RES  = 3'd0,
    ADDR_LOW  = 3'd1,
    ADDR_HIGH = 3'd2,
    ADDR_TRIM = 3'd3,
    ADDR_CTRL = 3'd4
  } tod_addr_e;

  localparam int unsigned TOD_ADDR_W = 3;
endpackage

// File: rtl/tod_frac_acc.sv
module tod_frac_acc #(
  parameter int unsigned FRAC_W    = 32,
  parameter int unsigned STEP_W    = 4,
  parameter int unsigned BASE_STEP = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_en_i,
  input  logic              clear_i,
  input  logic [FRAC_W-1:0] trim_i,
  output logic [FRAC_W-1:0] frac_o,
  output logic [STEP_W-1:0] step_o
);
  localparam logic [STEP_W-1:0] BASE = STEP_W'(BASE_STEP);

  logic [FRAC_W-1:0] frac_q;
  logic [FRAC_W-1:0] mag;
  logic [FRAC_W:0]   sum, diff;
  logic              neg;

  assign neg  = trim_i[FRAC_W-1];
  assign mag  = {1'b0, trim_i[FRAC_W-2:0]};
  assign sum  = {1'b0, frac_q} + {1'b0, mag};
  assign diff = {1'b0, frac_q} - {1'b0, mag};

  // carry -> one extra ns, borrow -> one ns less
  always_comb begin
    if (neg) step_o = BASE - STEP_W'(diff[FRAC_W]);
    else     step_o = BASE + STEP_W'(sum[FRAC_W]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        frac_q <= '0;
    else if (clear_i)   frac_q <= '0;
    else if (tick_en_i) frac_q <= neg ? diff[FRAC_W-1:0] : sum[FRAC_W-1:0];
  end

  assign frac_o = frac_q;
endmodule

// File: rtl/tod_ns_count.sv
module tod_ns_count #(
  parameter int unsigned NS_W   = 40,
  parameter int unsigned STEP_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_en_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              load_i,
  input  logic [NS_W-1:0]   load_val_i,
  output logic [NS_W-1:0]   count_o
);
  logic [NS_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        count_q <= '0;
    else if (load_i)    count_q <= load_val_i;
    else if (tick_en_i) count_q <= count_q + NS_W'(step_i);
  end

  assign count_o = count_q;
endmodule

// File: rtl/tod_regs.sv
module tod_regs
  import tod_pkg::*;
#(
  parameter int unsigned NS_W   = 40,
  parameter int unsigned DW     = 32,
  parameter int unsigned FRAC_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic                  re_i,
  input  logic [TOD_ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]         wdata_i,
  input  logic [NS_W-1:0]       time_i,
  input  logic [FRAC_W-1:0]     frac_i,
  output logic [DW-1:0]         rdata_o,
  output logic [FRAC_W-1:0]     trim_o,
  output logic                  stop_o,
  output logic                  commit_o,
  output logic [NS_W-1:0]       load_val_o,
  output logic [DW-1:0]         stage_o
);
  localparam int unsigned HI_W = NS_W - DW;

  logic [DW-1:0]     stage_q, rdata_q;
  logic [FRAC_W-1:0] trim_q;
  logic [NS_W-1:0]   snap_q;
  logic              stop_q;
  logic [DW-1:0]     rd_mux;

  assign commit_o   = we_i && (addr_i == ADDR_HIGH);
  assign load_val_o = {wdata_i[HI_W-1:0], stage_q};

  always_comb begin
    unique case (addr_i)
      ADDR_RES:  rd_mux = DW'(frac_i);
      ADDR_LOW:  rd_mux = snap_q[DW-1:0];
      ADDR_HIGH: rd_mux = {{(DW-HI_W){1'b0}}, snap_q[NS_W-1:DW]};
      ADDR_TRIM: rd_mux = DW'(trim_q);
      ADDR_CTRL: rd_mux = {stop_q, {(DW-1){1'b0}}};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      rdata_q <= '0;
      trim_q  <= '0;
      snap_q  <= '0;
      stop_q  <= 1'b1;
    end else begin
      if (re_i) begin
        rdata_q <= rd_mux;
        if (addr_i == ADDR_RES) snap_q <= time_i;
      end
      if (we_i) begin
        unique case (addr_i)
          ADDR_LOW:  stage_q <= wdata_i;
          ADDR_TRIM: trim_q  <= FRAC_W'(wdata_i);
          ADDR_CTRL: stop_q  <= wdata_i[DW-1];
          default:   ;
        endcase
      end
    end
  end

  assign rdata_o = rdata_q;
  assign trim_o  = trim_q;
  assign stop_o  = stop_q;
  assign stage_o = stage_q;
endmodule

// File: rtl/tod_trim_counter.sv
module tod_trim_counter
  import tod_pkg::*;
#(
  parameter int unsigned NS_W      = 40,
  parameter int unsigned DW        = 32,
  parameter int unsigned FRAC_W    = 32,
  parameter int unsigned BASE_STEP = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bus_we_i,
  input  logic                  bus_re_i,
  input  logic [TOD_ADDR_W-1:0] bus_addr_i,
  input  logic [DW-1:0]         bus_wdata_i,
  output logic [DW-1:0]         bus_rdata_o,
  output logic [NS_W-1:0]       time_ns_o
);
  localparam int unsigned STEP_W = $clog2(BASE_STEP + 2) + 1;

  logic [FRAC_W-1:0] trim, frac;
  logic [STEP_W-1:0] step;
  logic              ctrl_stop, commit, tick_en;
  logic [NS_W-1:0]   load_val;
  logic [DW-1:0]     stage;

  assign tick_en = !ctrl_stop && !commit;

  tod_regs #(.NS_W(NS_W), .DW(DW), .FRAC_W(FRAC_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(bus_we_i), .re_i(bus_re_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .time_i(time_ns_o), .frac_i(frac),
    .rdata_o(bus_rdata_o), .trim_o(trim), .stop_o(ctrl_stop),
    .commit_o(commit), .load_val_o(load_val), .stage_o(stage)
  );

  tod_frac_acc #(.FRAC_W(FRAC_W), .STEP_W(STEP_W), .BASE_STEP(BASE_STEP)) u_acc (
    .clk_i, .rst_ni,
    .tick_en_i(tick_en), .clear_i(commit), .trim_i(trim),
    .frac_o(frac), .step_o(step)
  );

  tod_ns_count #(.NS_W(NS_W), .STEP_W(STEP_W)) u_cnt (
    .clk_i, .rst_ni,
    .tick_en_i(tick_en), .step_i(step),
    .load_i(commit), .load_val_i(load_val),
    .count_o(time_ns_o)
  );
endmodule

// File: rtl/tod_trim_chk.sv
module tod_trim_chk #(
  parameter int unsigned NS_W   = 40,
  parameter int unsigned DW     = 32,
  parameter int unsigned FRAC_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stop_i,
  input logic              commit_i,
  input logic [FRAC_W-1:0] trim_i,
  input logic [FRAC_W-1:0] frac_i,
  input logic [NS_W-1:0]   load_val_i,
  input logic [NS_W-1:0]   time_i,
  input logic              re_i,
  input logic [2:0]        addr_i,
  input logic [DW-1:0]     rdata_i
);
  a_r2_hold_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !commit_i) |=> ($stable(time_i) && $stable(frac_i)));

  a_r3_step_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_i && !commit_i) |=>
      (NS_W'(time_i - $past(time_i)) >= NS_W'(7) && NS_W'(time_i - $past(time_i)) <= NS_W'(9)));

  a_r4_add_never_slow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_i && !commit_i && !trim_i[FRAC_W-1]) |=> (NS_W'(time_i - $past(time_i)) != NS_W'(7)));

  a_r5_sub_never_fast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_i && !commit_i && trim_i[FRAC_W-1]) |=> (NS_W'(time_i - $past(time_i)) != NS_W'(9)));

  a_r8_commit_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> (time_i == $past(load_val_i) && frac_i == '0));

  a_r10_high_rsv_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == 3'd2) |=> (rdata_i[DW-1:NS_W-DW] == '0));
endmodule

bind tod_trim_counter tod_trim_chk #(.NS_W(NS_W), .DW(DW), .FRAC_W(FRAC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .stop_i(ctrl_stop), .commit_i(commit),
  .trim_i(trim), .frac_i(frac), .load_val_i(load_val), .time_i(time_ns_o),
  .re_i(bus_re_i), .addr_i(bus_addr_i), .rdata_i(bus_rdata_o)
);

// File: tb/tod_trim_counter_tb.sv
module tod_trim_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [39:0] tns;

  int n_vec = 0, n_bad = 0, cycles = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #5 clk = ~clk;

  tod_trim_counter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_re_i(re),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .time_ns_o(tns)
  );

  // behavioural reference
  logic [39:0] m_ns, m_snap;
  logic [31:0] m_frac, m_trim, m_stage, m_rd;
  bit          m_stop;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ns = 0; m_snap = 0; m_frac = 0; m_trim = 0; m_stage = 0; m_rd = 0; m_stop = 1;
    end else begin
      logic [39:0] old_ns;
      logic [32:0] acc;
      bit          load;
      old_ns = m_ns;
      load = we && addr == 3'd2;
      if (load) begin
        m_ns = {wdata[7:0], m_stage};
        m_frac = 0;
      end else if (!m_stop) begin
        if (m_trim[31]) begin
          acc = {1'b0, m_frac} - {2'b0, m_trim[30:0]};
          m_ns = m_ns + (acc[32] ? 40'd7 : 40'd8);
        end else begin
          acc = {1'b0, m_frac} + {2'b0, m_trim[30:0]};
          m_ns = m_ns + (acc[32] ? 40'd9 : 40'd8);
        end
      end
      if (re) begin
        case (addr)
          3'd0: begin m_rd = m_frac_prev; m_snap = old_ns; end
          3'd1: m_rd = m_snap[31:0];
          3'd2: m_rd = {24'h0, m_snap[39:32]};
          3'd3: m_rd = m_trim;
          3'd4: m_rd = {m_stop, 31'h0};
          default: m_rd = 0;
        endcase
      end
      if (!load && !m_stop) m_frac = acc[31:0];
      if (we) begin
        case (addr)
          3'd1: m_stage = wdata;
          3'd3: m_trim = wdata;
          3'd4: m_stop = wdata[31];
          default: ;
        endcase
      end
    end
  end

  // fraction value before the edge, for residue reads
  logic [31:0] m_frac_prev;
  always @(negedge clk) m_frac_prev = m_frac;

  always @(negedge clk) begin
    if (!done) begin
      n_vec++;
      if (tns !== m_ns) begin
        n_bad++;
        $display("FAIL %s time: got %h expected %h", cur_req, tns, m_ns);
      end
      n_vec++;
      if (rdata !== m_rd) begin
        n_bad++;
        $display("FAIL %s rdata: got %h expected %h", cur_req, rdata, m_rd);
      end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      we = 0; re = 0;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1; re = 0; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input logic [2:0] a);
    @(negedge clk);
    re = 1; we = 0; addr = a;
    @(negedge clk);
    re = 0;
  endtask

  task automatic finish_run;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected under 100000", cycles);
      finish_run();
    end
  end

  initial begin
    cur_req = "R1"; step(3);
    rst_n = 1; step(2);
    rd(3'd4); rd(3'd3); rd(3'd0);
    cur_req = "R12"; wr(3'd3, 32'h4000_0000); rd(3'd3);
    cur_req = "R2"; step(6); rd(3'd0);
    cur_req = "R11"; wr(3'd4, 32'h0); rd(3'd4);
    cur_req = "R4"; step(12); rd(3'd0);
    cur_req = "R6"; rd(3'd0); step(5); rd(3'd1); rd(3'd2); step(3); rd(3'd1);
    cur_req = "R5"; wr(3'd3, 32'hC000_0000); step(12); rd(3'd0);
    cur_req = "R3"; wr(3'd3, 32'h8000_0000); step(8); wr(3'd3, 32'h0); step(8);
    cur_req = "R7"; wr(3'd3, 32'h7FFF_FFDD); step(4);
    wr(3'd1, 32'hFFFF_FFE0); step(4);
    cur_req = "R8"; wr(3'd2, 32'h0000_00FF); rd(3'd0); step(2);
    cur_req = "R9"; step(10); rd(3'd0); rd(3'd1); rd(3'd2);
    cur_req = "R10"; wr(3'd1, 32'h1234_5678); wr(3'd2, 32'hABCD_EF12);
    rd(3'd0); rd(3'd2); rd(3'd1);
    cur_req = "R11"; wr(3'd4, 32'h8000_0000); step(5); rd(3'd4);
    cur_req = "R2"; wr(3'd3, 32'h8000_1234); step(4); rd(3'd0);
    cur_req = "R8"; wr(3'd1, 32'hDEAD_0000); wr(3'd2, 32'h5A); step(3); rd(3'd0);
    cur_req = "R11"; wr(3'd4, 32'h7FFF_FFFF); step(20);
    cur_req = "R5"; wr(3'd3, 32'hFFFF_FFFF); step(10);
    cur_req = "R12"; wr(3'd3, 32'h0000_0001); rd(3'd3); step(6);
    finish_run();
  end
endmodule